// File: doc/BRIEF.md
# Basic CPU control signal generator

This block is the control glue of a small 16-bit accumulator machine. The decoded opcode lines, the one-hot timing-slot lines, the indirect-address bit, the interrupt-cycle flag and the low twelve bits of the instruction word come in. The block turns them into four sets of control signals:

- the load, increment and clear strobes of the address register;
- the memory read strobe;
- the interrupt-enable flag;
- the 3-bit select code that picks the source driving the common bus.

Each strobe is a fixed sum of opcode-by-slot products that belongs to one instruction set. The block is not a general-purpose decoder.

Two bus requests are formed inside the block: the address register as source and the memory as source. The other five requests come from neighbouring control logic. All seven are encoded into the select code. The interrupt-enable flag is the only state in the block. It is a JK flip-flop that updates on the rising clock edge and has a synchronous reset.

Top module: `ctl_strobe_gen`

## Requirements
- R1: `ar_load` is high exactly when (not `intr_cyc` and slot 0) or (not `intr_cyc` and slot 2) or (opcode line 7 low, `ind_bit` high and slot 3).
- R2: `ar_clear` is high exactly when `intr_cyc` is high in slot 0. `ar_incr` is high exactly when opcode line 5 is high in slot 4.
- R3: `mem_read` is high exactly when (not `intr_cyc` and slot 1) or (opcode line 7 low, `ind_bit` high and slot 3) or (any of opcode lines 0 to 3 high in slot 4).
- R4: An I/O-class step is opcode line 7 high, `ind_bit` high and slot 3. An I/O-class step with instruction bit 7 set (and no clear condition) makes `ien_q` 1 after the next rising edge.
- R5: An I/O-class step with instruction bit 6 set, or `intr_cyc` high in slot 2, makes `ien_q` 0 after the next rising edge, provided no set condition is present. A register-class step (opcode line 7 high, `ind_bit` low, slot 3) never changes `ien_q`, whatever bits 6 and 7 hold.
- R6: When the set and clear conditions are present together, `ien_q` toggles. When neither is present, `ien_q` holds.
- R7: Bus request k (k = 1 to 7) gives `bus_sel` = k in binary (bit 0 is the OR of requests 1, 3, 5 and 7). Request 1 is opcode line 4 in slot 4 or opcode line 5 in slot 5. Requests 2 to 6 are `ext_req` bits 0 to 4. Request 7 uses exactly the product terms of `mem_read`.
- R8: With no request active, `bus_sel` is 000.
- R9: `rst` high at a rising edge makes `ien_q` 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_dec | input | 8 | Decoded opcode lines, one-hot |
| t_slot | input | 16 | Timing-slot lines, one-hot |
| ind_bit | input | 1 | Indirect-address bit of the instruction |
| intr_cyc | input | 1 | Interrupt-cycle flag |
| ir_bits | input | 12 | Low instruction-word bits |
| ext_req | input | 5 | Bus requests 2 to 6 from neighbouring control |
| ar_load | output | 1 | Address register load strobe |
| ar_incr | output | 1 | Address register increment strobe |
| ar_clear | output | 1 | Address register clear strobe |
| mem_read | output | 1 | Memory read strobe |
| ien_q | output | 1 | Interrupt-enable flag |
| bus_sel | output | 3 | Common-bus source select code |

## Verification
The hardest case to reach is the toggle of the interrupt-enable flag. It needs an I/O-class step in slot 3 whose instruction word carries bits 6 and 7 together, and the flag must already hold a known value when that step arrives. The stimulus first sets the flag, then applies the dual-bit step twice, so it watches the flag flip both ways. Random vectors come next. They keep the opcode and slot lines one-hot and leave the external requests quiet whenever an internal bus request is active, so the encoder only ever sees one-hot requests.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;

   // smallest widths the fixed product terms can live with
   localparam int unsigned OPS_MIN   = 8;
   localparam int unsigned SLOTS_MIN = 6;
   localparam int unsigned IRB_MIN   = 8;
   localparam int unsigned SRC_MIN   = 3;

   // opcode line positions the product terms depend on
   localparam int unsigned OP_MREF_HI = 3;   // lines 0..3 read an operand
   localparam int unsigned OP_JUMP    = 4;
   localparam int unsigned OP_CALL    = 5;
   localparam int unsigned OP_NONMEM  = 7;

   // instruction-word bits steering the interrupt enable
   localparam int unsigned IRB_IEN_OFF = 6;
   localparam int unsigned IRB_IEN_ON  = 7;

   typedef struct packed {
      logic ld;
      logic inc;
      logic clr;
   } areg_ctl_t;

   typedef enum logic [1:0] {
      ENC_OR_TREE  = 2'd0,
      ENC_PRIORITY = 2'd1
   } enc_style_e;

endpackage

// File: rtl/ctl_term_decode.sv
module ctl_term_decode
   import cpu_ctl_pkg::*;
#(
   parameter int unsigned NUM_OPS   = 8,
   parameter int unsigned NUM_SLOTS = 16
) (
   input  logic [NUM_OPS-1:0]   op_dec,
   input  logic [NUM_SLOTS-1:0] t_slot,
   input  logic                 ind_bit,
   input  logic                 intr_cyc,
   output areg_ctl_t            ar_ctl,
   output logic                 mem_rd,
   output logic                 io_step,
   output logic                 src_addr_req,
   output logic                 src_mem_req
);

   logic fetch_rd;
   logic indir_step;
   logic opnd_rd;
   logic unused_lines;

   // operand fetch for the indirect address, non-I/O opcode
   assign indir_step = ~op_dec[OP_NONMEM] & ind_bit & t_slot[3];
   assign fetch_rd   = ~intr_cyc & t_slot[1];
   assign opnd_rd    = (|op_dec[OP_MREF_HI:0]) & t_slot[4];

   assign ar_ctl.ld  = (~intr_cyc & t_slot[0]) | (~intr_cyc & t_slot[2]) | indir_step;
   assign ar_ctl.clr = intr_cyc & t_slot[0];
   assign ar_ctl.inc = op_dec[OP_CALL] & t_slot[4];

   assign mem_rd     = fetch_rd | indir_step | opnd_rd;
   assign io_step    = op_dec[OP_NONMEM] & ind_bit & t_slot[3];

   assign src_addr_req = (op_dec[OP_JUMP] & t_slot[4]) | (op_dec[OP_CALL] & t_slot[5]);
   assign src_mem_req  = mem_rd;

   generate
      if (NUM_SLOTS > SLOTS_MIN) begin : g_spare_slots
         assign unused_lines = ^{t_slot[NUM_SLOTS-1:SLOTS_MIN], op_dec[6]};
      end else begin : g_no_spare
         assign unused_lines = op_dec[6];
      end
   endgenerate

endmodule

// File: rtl/ctl_ien_jk.sv
module ctl_ien_jk (
   input  logic clk,
   input  logic rst,
   input  logic io_step,
   input  logic ir_on,
   input  logic ir_off,
   input  logic intr_cyc,
   input  logic slot2,
   output logic ien_q
);

   logic j_in;
   logic k_in;
   logic ien_d;

   assign j_in = io_step & ir_on;
   assign k_in = (io_step & ir_off) | (intr_cyc & slot2);

   always_comb begin
      unique case ({j_in, k_in})
         2'b10:   ien_d = 1'b1;
         2'b01:   ien_d = 1'b0;
         2'b11:   ien_d = ~ien_q;
         default: ien_d = ien_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) ien_q <= 1'b0;
      else     ien_q <= ien_d;
   end

endmodule

// File: rtl/ctl_src_encoder.sv
module ctl_src_encoder
   import cpu_ctl_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 7,
   parameter int unsigned SEL_W     = 3,
   parameter enc_style_e  ENC_STYLE = ENC_OR_TREE
) (
   input  logic [NUM_SRC-1:0] req,
   output logic [SEL_W-1:0]   sel
);

   // request i carries code i+1; column b collects the requests whose code has bit b set
   function automatic logic [NUM_SRC-1:0] column_mask(int unsigned b);
      logic [NUM_SRC-1:0] m;
      for (int unsigned i = 0; i < NUM_SRC; i++) begin
         m[i] = ((i + 1) >> b) & 1;
      end
      return m;
   endfunction

   generate
      if (ENC_STYLE == ENC_OR_TREE) begin : g_or_tree
         for (genvar b = 0; b < SEL_W; b++) begin : g_col
            localparam logic [NUM_SRC-1:0] COL_MASK = column_mask(b);
            assign sel[b] = |(req & COL_MASK);
         end
      end else begin : g_priority
         always_comb begin
            sel = '0;
            for (int unsigned i = 0; i < NUM_SRC; i++) begin
               if (req[i]) sel = SEL_W'(i + 1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ctl_strobe_gen.sv
module ctl_strobe_gen
   import cpu_ctl_pkg::*;
#(
   parameter int unsigned NUM_OPS   = 8,
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned IR_W      = 12,
   parameter int unsigned NUM_SRC   = 7,
   parameter enc_style_e  ENC_STYLE = ENC_OR_TREE,
   localparam int unsigned NUM_EXT  = NUM_SRC - 2,
   localparam int unsigned SEL_W    = $clog2(NUM_SRC + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_OPS-1:0]   op_dec,
   input  logic [NUM_SLOTS-1:0] t_slot,
   input  logic                 ind_bit,
   input  logic                 intr_cyc,
   input  logic [IR_W-1:0]      ir_bits,
   input  logic [NUM_EXT-1:0]   ext_req,
   output logic                 ar_load,
   output logic                 ar_incr,
   output logic                 ar_clear,
   output logic                 mem_read,
   output logic                 ien_q,
   output logic [SEL_W-1:0]     bus_sel
);

   generate
      if (NUM_OPS < OPS_MIN) begin : g_bad_ops
         $error("ctl_strobe_gen: NUM_OPS below minimum");
      end
      if (NUM_SLOTS < SLOTS_MIN) begin : g_bad_slots
         $error("ctl_strobe_gen: NUM_SLOTS below minimum");
      end
      if (IR_W < IRB_MIN) begin : g_bad_ir
         $error("ctl_strobe_gen: IR_W below minimum");
      end
      if (NUM_SRC < SRC_MIN) begin : g_bad_src
         $error("ctl_strobe_gen: NUM_SRC below minimum");
      end
   endgenerate

   areg_ctl_t          ar_ctl;
   logic               io_step;
   logic               x_addr;
   logic               x_mem;
   logic [NUM_SRC-1:0] src_req;
   logic               unused_ir;

   ctl_term_decode #(
      .NUM_OPS   (NUM_OPS),
      .NUM_SLOTS (NUM_SLOTS)
   ) term_i (
      .op_dec       (op_dec),
      .t_slot       (t_slot),
      .ind_bit      (ind_bit),
      .intr_cyc     (intr_cyc),
      .ar_ctl       (ar_ctl),
      .mem_rd       (mem_read),
      .io_step      (io_step),
      .src_addr_req (x_addr),
      .src_mem_req  (x_mem)
   );

   ctl_ien_jk ien_i (
      .clk      (clk),
      .rst      (rst),
      .io_step  (io_step),
      .ir_on    (ir_bits[IRB_IEN_ON]),
      .ir_off   (ir_bits[IRB_IEN_OFF]),
      .intr_cyc (intr_cyc),
      .slot2    (t_slot[2]),
      .ien_q    (ien_q)
   );

   // lowest code: address register, highest code: memory
   assign src_req = {x_mem, ext_req, x_addr};

   ctl_src_encoder #(
      .NUM_SRC   (NUM_SRC),
      .SEL_W     (SEL_W),
      .ENC_STYLE (ENC_STYLE)
   ) enc_i (
      .req (src_req),
      .sel (bus_sel)
   );

   assign ar_load  = ar_ctl.ld;
   assign ar_incr  = ar_ctl.inc;
   assign ar_clear = ar_ctl.clr;

   generate
      if (IR_W > IRB_MIN) begin : g_ir_wide
         assign unused_ir = ^{ir_bits[IR_W-1:IRB_MIN], ir_bits[IRB_IEN_OFF-1:0]};
      end else begin : g_ir_narrow
         assign unused_ir = ^ir_bits[IRB_IEN_OFF-1:0];
      end
   endgenerate

endmodule

// File: rtl/ctl_strobe_gen_chk.sv
module ctl_strobe_gen_chk #(
   parameter int unsigned NUM_OPS   = 8,
   parameter int unsigned NUM_SLOTS = 16,
   parameter int unsigned IR_W      = 12,
   parameter int unsigned NUM_SRC   = 7,
   parameter int unsigned SEL_W     = 3
) (
   input logic                 clk,
   input logic                 rst,
   input logic [NUM_OPS-1:0]   op_dec,
   input logic [NUM_SLOTS-1:0] t_slot,
   input logic                 ind_bit,
   input logic                 intr_cyc,
   input logic [IR_W-1:0]      ir_bits,
   input logic [NUM_SRC-3:0]   ext_req,
   input logic                 ar_load,
   input logic                 ar_incr,
   input logic                 ar_clear,
   input logic                 mem_read,
   input logic                 ien_q,
   input logic [SEL_W-1:0]     bus_sel
);

   logic io_cls;
   logic want_set;
   logic want_clr;
   logic addr_src;
   logic unused_chk;

   assign io_cls   = op_dec[7] & ind_bit & t_slot[3];
   assign want_set = io_cls & ir_bits[7];
   assign want_clr = (io_cls & ir_bits[6]) | (intr_cyc & t_slot[2]);
   assign addr_src = (op_dec[4] & t_slot[4]) | (op_dec[5] & t_slot[5]);
   assign unused_chk = ^{ar_incr, ir_bits, op_dec, t_slot};

   assert_ld_intr_indirect_R1: assert property (@(posedge clk) disable iff (rst)
      (ar_load && intr_cyc) |-> (t_slot[3] && ind_bit && !op_dec[7]));

   assert_clr_only_intr_R2: assert property (@(posedge clk) disable iff (rst)
      ar_clear |-> intr_cyc);

   assert_ien_set_R4: assert property (@(posedge clk) disable iff (rst)
      (want_set && !want_clr) |=> ien_q);

   assert_ien_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (want_clr && !want_set) |=> !ien_q);

   assert_ien_hold_R6: assert property (@(posedge clk) disable iff (rst)
      (!want_set && !want_clr) |=> $stable(ien_q));

   assert_ien_toggle_R6: assert property (@(posedge clk) disable iff (rst)
      (want_set && want_clr) |=> (ien_q != $past(ien_q)));

   assert_mem_sel_R7: assert property (@(posedge clk) disable iff (rst)
      (mem_read && !addr_src && ext_req == '0) |-> (bus_sel == SEL_W'(NUM_SRC)));

   assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
      (!mem_read && !addr_src && ext_req == '0) |-> (bus_sel == '0));

   assert_reset_ien_R9: assert property (@(posedge clk)
      $past(rst) |-> !ien_q);

endmodule

bind ctl_strobe_gen ctl_strobe_gen_chk #(
   .NUM_OPS   (NUM_OPS),
   .NUM_SLOTS (NUM_SLOTS),
   .IR_W      (IR_W),
   .NUM_SRC   (NUM_SRC),
   .SEL_W     (SEL_W)
) chk_i (
   .clk      (clk),
   .rst      (rst),
   .op_dec   (op_dec),
   .t_slot   (t_slot),
   .ind_bit  (ind_bit),
   .intr_cyc (intr_cyc),
   .ir_bits  (ir_bits),
   .ext_req  (ext_req),
   .ar_load  (ar_load),
   .ar_incr  (ar_incr),
   .ar_clear (ar_clear),
   .mem_read (mem_read),
   .ien_q    (ien_q),
   .bus_sel  (bus_sel)
);

// File: tb/ctl_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module ctl_strobe_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  op_dec = '0;
   logic [15:0] t_slot = '0;
   logic        ind_bit = 1'b0;
   logic        intr_cyc = 1'b0;
   logic [11:0] ir_bits = '0;
   logic [4:0]  ext_req = '0;
   logic        ar_load, ar_incr, ar_clear, mem_read, ien_q;
   logic [2:0]  bus_sel;

   always #2.5 clk = ~clk;

   ctl_strobe_gen dut_i (
      .clk(clk), .rst(rst), .op_dec(op_dec), .t_slot(t_slot),
      .ind_bit(ind_bit), .intr_cyc(intr_cyc), .ir_bits(ir_bits),
      .ext_req(ext_req), .ar_load(ar_load), .ar_incr(ar_incr),
      .ar_clear(ar_clear), .mem_read(mem_read), .ien_q(ien_q),
      .bus_sel(bus_sel)
   );

   typedef struct {
      logic       ld, inc, clr, rd, ien;
      logic [2:0] sel;
      int         nreq;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   logic ien_model = 1'b0;
   bit   done = 0;

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // driver: applies one step and queues what the ports must show after the next edge
   task automatic apply(logic rv, logic [7:0] d, logic [15:0] t, logic i, logic r,
                        logic [11:0] b, logic [4:0] e);
      exp_t x;
      logic io, js, kc, x1, x7;
      logic [6:0] req;
      @(negedge clk);
      rst = rv; op_dec = d; t_slot = t; ind_bit = i; intr_cyc = r; ir_bits = b; ext_req = e;
      // R1, R2, R3 strobes
      x.ld  = (!r && t[0]) || (!r && t[2]) || (!d[7] && i && t[3]);
      x.clr = r && t[0];
      x.inc = d[5] && t[4];
      x.rd  = (!r && t[1]) || (!d[7] && i && t[3]) || ((|d[3:0]) && t[4]);
      // R7 request vector
      x1  = (d[4] && t[4]) || (d[5] && t[5]);
      x7  = x.rd;
      req = {x7, e, x1};
      x.nreq = $countones(req);
      x.sel = 3'd0;                          // R8 default
      for (int k = 0; k < 7; k++) if (req[k]) x.sel = 3'(k + 1);
      // R4..R6, R9 interrupt enable
      io = d[7] && i && t[3];
      js = io && b[7];
      kc = (io && b[6]) || (r && t[2]);
      if (rv)            ien_model = 1'b0;
      else if (js && kc) ien_model = !ien_model;
      else if (js)       ien_model = 1'b1;
      else if (kc)       ien_model = 1'b0;
      x.ien = ien_model;
      exp_q.push_back(x);
   endtask

   // monitor: samples 1 ns after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t x;
            x = exp_q.pop_front();
            check("R1 ar_load",  {7'd0, ar_load},  {7'd0, x.ld});
            check("R2 ar_clear", {7'd0, ar_clear}, {7'd0, x.clr});
            check("R2 ar_incr",  {7'd0, ar_incr},  {7'd0, x.inc});
            check("R3 mem_read", {7'd0, mem_read}, {7'd0, x.rd});
            check("R4 R5 R6 R9 ien_q", {7'd0, ien_q}, {7'd0, x.ien});
            check("R7 R8 bus_sel", {5'd0, bus_sel}, {5'd0, x.sel});
            check("R7 one-hot requests", (x.nreq <= 1) ? 8'd1 : 8'd0, 8'd1);
         end
      end
   end

   function automatic logic [7:0] oh8(int k);
      return 8'(1 << k);
   endfunction
   function automatic logic [15:0] oh16(int k);
      return 16'(1 << k);
   endfunction

   initial begin
      // R9 reset
      apply(1, 0, 0, 0, 0, 12'h0, 0);
      apply(1, oh8(7), oh16(3), 1, 0, 12'h080, 0);
      apply(0, 0, 0, 0, 0, 12'h0, 0);                       // R8 idle bus
      apply(0, oh8(0), oh16(0), 0, 0, 12'h0, 0);            // R1 slot 0
      apply(0, oh8(0), oh16(1), 0, 0, 12'h0, 0);            // R3 fetch read, sel 7
      apply(0, oh8(0), oh16(2), 0, 0, 12'h0, 0);            // R1 slot 2
      apply(0, oh8(2), oh16(3), 1, 0, 12'h0, 0);            // R1 R3 indirect
      apply(0, oh8(2), oh16(3), 0, 0, 12'h0, 0);            // direct: nothing
      apply(0, oh8(3), oh16(4), 0, 0, 12'h0, 0);            // R3 operand read
      apply(0, oh8(4), oh16(4), 0, 0, 12'h0, 0);            // R7 request 1
      apply(0, oh8(5), oh16(5), 0, 0, 12'h0, 0);            // R7 request 1
      apply(0, oh8(5), oh16(4), 0, 0, 12'h0, 0);            // R2 increment
      apply(0, 0, oh16(0), 0, 1, 12'h0, 0);                 // R2 clear
      apply(0, oh8(7), oh16(3), 1, 0, 12'h080, 0);          // R4 set
      apply(0, oh8(7), oh16(3), 0, 0, 12'h040, 0);          // R5 register class ignored
      apply(0, oh8(7), oh16(3), 1, 0, 12'h0C0, 0);          // R6 toggle to 0
      apply(0, oh8(7), oh16(3), 1, 0, 12'h0C0, 0);          // R6 toggle to 1
      apply(0, oh8(7), oh16(3), 1, 0, 12'h040, 0);          // R5 clear by bit 6
      apply(0, oh8(7), oh16(3), 0, 0, 12'h080, 0);          // R5 register class no set
      apply(0, oh8(7), oh16(3), 1, 0, 12'h080, 0);          // R4 set
      apply(0, 0, oh16(2), 0, 1, 12'h0, 0);                 // R5 clear in interrupt
      for (int k = 0; k < 5; k++) apply(0, 0, 0, 0, 0, 12'h0, 5'(1 << k)); // R7 ext
      apply(1, 0, 0, 0, 0, 12'h0, 0);                       // R9
      apply(0, 0, 0, 0, 0, 12'h0, 0);
      for (int n = 0; n < 600; n++) begin
         logic [7:0]  d;
         logic [15:0] t;
         logic        i, r, busy;
         logic [4:0]  e;
         d = oh8($urandom % 8);
         t = oh16($urandom % 16);
         i = 1'($urandom);
         r = 1'($urandom);
         busy = (!r && t[1]) || (!d[7] && i && t[3]) || ((|d[3:0]) && t[4])
             || (d[4] && t[4]) || (d[5] && t[5]);
         e = (busy || ($urandom % 3 == 0)) ? 5'd0 : 5'(1 << ($urandom % 5));
         apply(0, d, t, i, r, 12'($urandom), e);
      end
      repeat (3) @(posedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            #50000;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule